// File: doc/BRIEF.md
# Buffered Compare Timer with PWM and Pulse-Generator Modes

This block is one channel of a general-purpose timer. An up counter advances on a count-enable tick and is compared against a compare register. The comparison raises a one-cycle match pulse. Counter wrap raises a one-cycle overflow pulse. A waveform output is built from these two events. Three operating modes are provided: an interval timer, a PWM generator with a power-of-two period, and a pulse generator whose output toggles on every match.

The compare register is write-only. Software updates it through a single write port. A staging (shadow) register can sit in front of it. With staging turned off, a write lands in both the compare register and the shadow register. With staging turned on, a write lands only in the shadow register. The shadow value is then copied into the compare register at a safe point: the PWM period wrap, or the start of a new pulse-generator cycle. This lets the duty or period be changed without a glitch in the waveform. A compare value of zero is a special case: it matches when the counter wraps, not when the counter reads zero.

Top module: `dbuf_cmp_timer`

## Requirements
- R1: Interval timer mode (mode 0, and also mode 3) with compare value C≠0 and tick held high:
  - match_o pulses for one cycle once every C+1 ticks.
  - The counter restarts from zero at each match.
  - wave_o stays low.
- R2: A compare value of zero matches on counter wrap, not at count zero. In the 8-bit timer and pulse-generator modes this gives one match every 256 ticks, and match_o and ovf_o pulse in the same cycle.
- R3: PWM mode (mode 1):
  - The counter runs freely from 0 to 2^n−1, with n = 6, 7, 8, 8 for pwm_sel = 0, 1, 2, 3.
  - wave_o goes high at the wrap and low after the match. It is high for C+1 cycles in each period when 0<C<2^n−1.
  - With C=0, wave_o stays low.
- R4: Pulse-generator mode (mode 2): each match clears the counter and toggles wave_o, so each phase lasts C+1 ticks.
- R5: ovf_o pulses for one cycle when the counter wraps to zero. The wrap point is at 255 in timer and pulse-generator modes and at 2^n−1 in PWM mode, so in PWM mode there is one overflow per 2^n ticks.
- R6: The counter advances only in cycles with tick high. With tick low, the outputs keep their values and no match or overflow pulse is produced.
- R7: With staging disabled, a write takes effect in the compare register at the next clock edge. In PWM mode this applies within the current period.
- R8: With staging enabled in PWM mode, a write changes only the shadow register. The compare register takes the new value at the next period wrap and holds it until then.
- R9: With staging enabled in pulse-generator mode, the shadow register is copied into the compare register at each cycle start, that is, at the match that clears the counter.
- R10: In timer mode the staging enable has no effect, and writes land in the compare register directly.
- R11: If a copy and a write fall in the same clock edge, the compare register takes the old shadow value. The new data stays in the shadow register for the next copy.
- R12: Reset, active low, sets the following to zero:
  - the counter, the compare register and the shadow register;
  - the staging enable;
  - match_o, ovf_o and wave_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Count enable; the counter advances in a cycle where it is high |
| wr_en | input | 1 | Write strobe for the compare value |
| wr_data | input | 8 | Compare value to write |
| stage_we | input | 1 | Write strobe for the staging enable bit |
| stage_val | input | 1 | New staging enable value (1 = shadow stage used) |
| mode | input | 2 | 0 timer, 1 PWM, 2 pulse generator, 3 timer |
| pwm_sel | input | 2 | PWM period select: n = 6, 7, 8, 8 |
| match_o | output | 1 | One-cycle pulse after a compare match |
| ovf_o | output | 1 | One-cycle pulse after a counter wrap |
| wave_o | output | 1 | Waveform output |

## Verification
The critical coincidence is a shadow-to-compare copy and a software write landing on the same clock edge. The bench provokes it in pulse-generator mode. It first stages one value. It then drives a second write so that the strobe is high at exactly the edge where the period match clears the counter.

The outcome is judged at the ports from the lengths of the next two match intervals. The first interval must reflect the earlier staged value and the second must reflect the colliding write. A design that lets the write win would shorten the first interval.

A second coincidence is match and wrap on the same edge, which happens when the compare value is zero. The bench checks that match_o and ovf_o pulse together in that case.

// File: rtl/dbt_pkg.sv
// Package: shared types and helpers for the buffered compare timer.
// Assumes a 2-bit mode code; code 3 is folded onto the interval timer.
package dbt_pkg;

    typedef enum logic [1:0] {
        MODE_TIMER = 2'd0,
        MODE_PWM   = 2'd1,
        MODE_PPG   = 2'd2
    } tmr_mode_e;

    // Map the raw mode code onto an operating mode.
    function automatic tmr_mode_e decode_mode(input logic [1:0] code);
        tmr_mode_e m;
        case (code)
            2'd1:    m = MODE_PWM;
            2'd2:    m = MODE_PPG;
            default: m = MODE_TIMER;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/dbt_counter.sv
// Module: dbt_counter
// Up counter with compare and wrap detection. The wrap point is all-ones,
// or 2^n-1 in PWM mode, where n is picked by pwm_sel from a generated table.
// A zero compare value matches on wrap. Timer and pulse-generator modes
// clear the counter on a match; PWM mode lets it run to the wrap point.
// Assumes tick is synchronous to clk. The event outputs are combinational
// and already qualified with tick.
module dbt_counter
    import dbt_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int PWM_MIN_N = 6,
    parameter int SEL_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  tmr_mode_e        mode,
    input  logic [SEL_W-1:0] pwm_sel,
    input  logic [CNT_W-1:0] cmp,
    output logic             hit_ev,
    output logic             wrap_ev
);

    localparam int NUM_SEL = 1 << SEL_W;

    logic [NUM_SEL-1:0][CNT_W-1:0] top_tab;
    logic [CNT_W-1:0]              cnt_q;
    logic [CNT_W-1:0]              top_val;
    logic                          at_top;
    logic                          cmp_eq;
    logic                          clr_on_hit;

    // One wrap point per period select, capped at the counter width.
    generate
        for (genvar g = 0; g < NUM_SEL; g++) begin : g_top
            localparam int N_RAW = PWM_MIN_N + g;
            localparam int N_EFF = (N_RAW > CNT_W) ? CNT_W : N_RAW;
            assign top_tab[g] = {CNT_W{1'b1}} >> (CNT_W - N_EFF);
        end
    endgenerate

    // Choose the wrap point and form the compare and wrap conditions.
    always_comb begin
        top_val    = (mode == MODE_PWM) ? top_tab[pwm_sel] : {CNT_W{1'b1}};
        at_top     = (cnt_q == top_val);
        cmp_eq     = (cmp != '0) ? (cnt_q == cmp) : at_top;
        clr_on_hit = (mode != MODE_PWM);
        hit_ev     = tick && cmp_eq;
        wrap_ev    = tick && at_top;
    end

    // Advance, clear on a match or wrap to zero on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            if ((clr_on_hit && cmp_eq) || at_top) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/dbt_cmp_regs.sv
// Module: dbt_cmp_regs
// Compare register, the shadow register in front of it, and the staging
// enable bit. A write goes to both registers when staging is off or the
// mode is the interval timer; otherwise it goes to the shadow only. A copy
// point moves the old shadow value into the compare register, so data
// written on the same edge waits for the next copy point.
// Assumes xfer_pt is already limited to PWM wrap or pulse-generator restart.
module dbt_cmp_regs
    import dbt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             stage_we,
    input  logic             stage_val,
    input  tmr_mode_e        mode,
    input  logic             xfer_pt,
    output logic [CNT_W-1:0] cmp_q,
    output logic             stage_q,
    output logic             xfer
);

    logic [CNT_W-1:0] shadow_q;
    logic             direct;

    // Decide where a write lands and whether a copy happens.
    always_comb begin
        direct = !stage_q || (mode == MODE_TIMER);
        xfer   = stage_q && xfer_pt;
    end

    // Staging enable bit, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= 1'b0;
        end else if (stage_we) begin
            stage_q <= stage_val;
        end
    end

    // The shadow register takes every write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else if (wr_en) begin
            shadow_q <= wr_data;
        end
    end

    // The compare register takes a direct write or the old shadow value at a copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (wr_en && direct) begin
            cmp_q <= wr_data;
        end else if (xfer) begin
            cmp_q <= shadow_q;
        end
    end

endmodule

// File: rtl/dbt_wave_gen.sv
// Module: dbt_wave_gen
// Registers the match and wrap pulses and builds the waveform:
// - timer mode: held low;
// - PWM: set at wrap and cleared at match, and a zero compare keeps it low;
// - pulse generator: toggled at every match.
// Assumes the event inputs are already qualified with tick.
module dbt_wave_gen
    import dbt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  tmr_mode_e mode,
    input  logic      hit_ev,
    input  logic      wrap_ev,
    input  logic      cmp_nz,
    output logic      match_o,
    output logic      ovf_o,
    output logic      wave_o
);

    logic wave_d;

    // Next waveform level for the current mode.
    always_comb begin
        case (mode)
            MODE_PWM: begin
                if (wrap_ev)     wave_d = cmp_nz;
                else if (hit_ev) wave_d = 1'b0;
                else             wave_d = wave_o;
            end
            MODE_PPG: wave_d = hit_ev ? !wave_o : wave_o;
            default:  wave_d = 1'b0;
        endcase
    end

    // Output registers for pulses and waveform.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_o <= 1'b0;
            ovf_o   <= 1'b0;
            wave_o  <= 1'b0;
        end else begin
            match_o <= hit_ev;
            ovf_o   <= wrap_ev;
            wave_o  <= wave_d;
        end
    end

endmodule

// File: rtl/dbuf_cmp_timer.sv
// Module: dbuf_cmp_timer (top)
// One timer channel: counter with compare, compare register with optional
// shadow staging, and waveform output. Copy points are the PWM wrap and the
// pulse-generator restart. Assumes all inputs are synchronous to clk.
module dbuf_cmp_timer
    import dbt_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int PWM_MIN_N = 6,
    parameter int SEL_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             stage_we,
    input  logic             stage_val,
    input  logic [1:0]       mode,
    input  logic [SEL_W-1:0] pwm_sel,
    output logic             match_o,
    output logic             ovf_o,
    output logic             wave_o
);

    tmr_mode_e        mode_e;
    logic [CNT_W-1:0] cmp_q;
    logic             stage_q;
    logic             xfer;
    logic             xfer_pt;
    logic             hit_ev;
    logic             wrap_ev;
    logic             cmp_nz;

    // Decode the mode and mark the copy points for staged data.
    always_comb begin
        mode_e  = decode_mode(mode);
        cmp_nz  = (cmp_q != '0);
        xfer_pt = ((mode_e == MODE_PWM) && wrap_ev) ||
                  ((mode_e == MODE_PPG) && hit_ev);
    end

    dbt_counter #(
        .CNT_W     (CNT_W),
        .PWM_MIN_N (PWM_MIN_N),
        .SEL_W     (SEL_W)
    ) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .mode    (mode_e),
        .pwm_sel (pwm_sel),
        .cmp     (cmp_q),
        .hit_ev  (hit_ev),
        .wrap_ev (wrap_ev)
    );

    dbt_cmp_regs #(
        .CNT_W (CNT_W)
    ) u_cmp_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .stage_we  (stage_we),
        .stage_val (stage_val),
        .mode      (mode_e),
        .xfer_pt   (xfer_pt),
        .cmp_q     (cmp_q),
        .stage_q   (stage_q),
        .xfer      (xfer)
    );

    dbt_wave_gen u_wave (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode_e),
        .hit_ev  (hit_ev),
        .wrap_ev (wrap_ev),
        .cmp_nz  (cmp_nz),
        .match_o (match_o),
        .ovf_o   (ovf_o),
        .wave_o  (wave_o)
    );

endmodule

// File: rtl/dbt_checker.sv
// Module: dbt_checker
// Temporal properties for dbuf_cmp_timer, attached through bind below.
module dbt_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [1:0]       mode,
    input logic             match_o,
    input logic             ovf_o,
    input logic             wave_o,
    input logic [CNT_W-1:0] cmp_q,
    input logic             stage_q,
    input logic             xfer
);

    logic is_timer;
    assign is_timer = (mode == 2'd0) || (mode == 2'd3);

    assert_timer_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        is_timer |=> !wave_o);

    assert_pwm_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o && ($past(mode) == 2'd1) && ($past(cmp_q) != '0) |-> wave_o);

    assert_ppg_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        match_o && ($past(mode) == 2'd2) |-> (wave_o != $past(wave_o)));

    assert_ovf_from_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> $past(tick));

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> (!match_o && !ovf_o));

    assert_staged_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stage_q && !is_timer && !xfer |=> $stable(cmp_q));

    assert_reset_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!match_o && !ovf_o && !wave_o && !stage_q));

endmodule

bind dbuf_cmp_timer dbt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .mode    (mode),
    .match_o (match_o),
    .ovf_o   (ovf_o),
    .wave_o  (wave_o),
    .cmp_q   (cmp_q),
    .stage_q (stage_q),
    .xfer    (xfer)
);

// File: tb/dbuf_cmp_timer_bench.sv
module dbuf_cmp_timer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic       stage_we = 1'b0;
    logic       stage_val = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [1:0] pwm_sel = 2'd0;
    logic       match_o, ovf_o, wave_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dbuf_cmp_timer u_dbuf_cmp_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
        .stage_we(stage_we), .stage_val(stage_val), .mode(mode), .pwm_sel(pwm_sel),
        .match_o(match_o), .ovf_o(ovf_o), .wave_o(wave_o)
    );

    typedef struct packed {
        logic [1:0]  md;
        logic [1:0]  sel;
        logic [7:0]  cv;
        logic [15:0] gap;
        logic [15:0] high;
    } vec_t;

    // mode, period select, compare, match gap, high cycles over two gaps
    localparam vec_t VECS [10] = '{
        '{2'd0, 2'd0, 8'd5,   16'd6,   16'd0},
        '{2'd3, 2'd0, 8'd0,   16'd256, 16'd0},
        '{2'd2, 2'd0, 8'd9,   16'd10,  16'd10},
        '{2'd2, 2'd0, 8'd0,   16'd256, 16'd256},
        '{2'd1, 2'd0, 8'd20,  16'd64,  16'd42},
        '{2'd1, 2'd1, 8'd100, 16'd128, 16'd202},
        '{2'd1, 2'd2, 8'd200, 16'd256, 16'd402},
        '{2'd1, 2'd3, 8'd10,  16'd256, 16'd22},
        '{2'd1, 2'd0, 8'd0,   16'd64,  16'd0},
        '{2'd0, 2'd0, 8'd255, 16'd256, 16'd0}
    };

    function automatic int now_cyc();
        return int'($time / 10);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; stage_we = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_stage(input logic v);
        stage_we = 1'b1; stage_val = v;
        @(negedge clk);
        stage_we = 1'b0;
    endtask

    task automatic wait_match(output int c);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!match_o && n < 2000);
        c = match_o ? now_cyc() : -1;
    endtask

    task automatic wait_ovf(output int c);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!ovf_o && n < 2000);
        c = ovf_o ? now_cyc() : -1;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: run did not finish");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int t0, t1, t2, t3, h, n, m, g;
        string tag;

        // R12: reset state
        do_reset();
        chk("R12 match", int'(match_o), 0);
        chk("R12 ovf", int'(ovf_o), 0);
        chk("R12 wave", int'(wave_o), 0);

        // Vector table: period and waveform per mode
        for (int i = 0; i < 10; i++) begin
            do_reset();
            mode = VECS[i].md; pwm_sel = VECS[i].sel;
            wr(VECS[i].cv);
            tick = 1'b1;
            if (VECS[i].cv == 8'd0)       tag = "R2";
            else if (VECS[i].md == 2'd1)  tag = "R3";
            else if (VECS[i].md == 2'd2)  tag = "R4";
            else                          tag = "R1";
            wait_match(t0);
            h = 0; n = 0; m = 0; g = 0;
            while (m < 2 && n < 3000) begin
                h += int'(wave_o);
                @(negedge clk);
                n++;
                if (match_o) begin
                    m++;
                    if (m == 1) g = n;
                end
            end
            chk({tag, " gap"}, g, int'(VECS[i].gap));
            chk({tag, " high"}, h, int'(VECS[i].high));
        end

        // R2 / R5: zero compare in timer mode gives match and wrap together
        do_reset();
        mode = 2'd0; wr(8'd0); tick = 1'b1;
        wait_match(t0);
        chk("R2 ovf with match", int'(ovf_o), 1);

        // R5 / R3: PWM overflow spacing and rising waveform at wrap
        do_reset();
        mode = 2'd1; pwm_sel = 2'd1; wr(8'd50); tick = 1'b1;
        wait_ovf(t0);
        chk("R3 wave at wrap", int'(wave_o), 1);
        wait_ovf(t1);
        chk("R5 ovf gap", t1 - t0, 128);

        // R6: no progress without tick, then tick every other cycle
        do_reset();
        mode = 2'd0; wr(8'd3); tick = 1'b0;
        m = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            m += int'(match_o) + int'(ovf_o);
        end
        chk("R6 idle pulses", m, 0);
        t0 = -1; t1 = -1;
        for (int k = 0; k < 60; k++) begin
            tick = ~tick;
            @(negedge clk);
            if (match_o) begin
                if (t0 < 0) t0 = now_cyc();
                else if (t1 < 0) t1 = now_cyc();
            end
        end
        chk("R6 half-rate gap", t1 - t0, 8);

        // R12 / R7: reset clears staging, so a PWM write acts within the period
        do_reset();
        set_stage(1'b1);
        do_reset();
        mode = 2'd1; pwm_sel = 2'd0; wr(8'd10); tick = 1'b1;
        wait_match(t0);
        wr(8'd30);
        wait_match(t1);
        chk("R7 R12 immediate write gap", t1 - t0, 20);

        // R8: staged PWM write waits for the wrap
        do_reset();
        mode = 2'd1; pwm_sel = 2'd0; wr(8'd10); set_stage(1'b1); tick = 1'b1;
        wait_match(t0);
        wr(8'd30);
        wait_match(t1);
        chk("R8 staged gap", t1 - t0, 84);

        // R9: staged pulse-generator write copied at the cycle start
        do_reset();
        mode = 2'd2; wr(8'd9); set_stage(1'b1); tick = 1'b1;
        wait_match(t0);
        wr(8'd4);
        wait_match(t1);
        chk("R9 first gap", t1 - t0, 10);
        wait_match(t2);
        chk("R9 second gap", t2 - t1, 5);

        // R10: timer mode ignores staging
        do_reset();
        mode = 2'd0; set_stage(1'b1); wr(8'd5); tick = 1'b1;
        wait_match(t0);
        wr(8'd3);
        wait_match(t1);
        chk("R10 direct gap", t1 - t0, 4);

        // R11: write on the same edge as a copy
        do_reset();
        mode = 2'd2; wr(8'd9); set_stage(1'b1); tick = 1'b1;
        wait_match(t0);
        wr(8'd6);
        repeat (8) @(negedge clk);
        wr_en = 1'b1; wr_data = 8'd3;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R11 match at collision", int'(match_o), 1);
        t1 = now_cyc();
        wait_match(t2);
        chk("R11 old shadow used", t2 - t1, 7);
        wait_match(t3);
        chk("R11 new data next", t3 - t2, 4);

        // R12: reset during activity clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R12 in reset", int'(match_o) + int'(ovf_o) + int'(wave_o), 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule